// File: doc/BRIEF.md
# Self-Synchronizing Serial Scrambler Link

This block whitens a serial bit stream and restores it at the far end. The transmit side holds a four-stage shift register. For each accepted message bit it XORs the bit with the XOR of stages 3 and 4, and it pushes that scrambled result back into stage 1. The receive side holds an identical register. It loads that register with the bits it receives, so the register is fed forward and not back. It XORs each received bit with the same two stages, which gives back the message. The receiver therefore needs no seed and no alignment step. Once enough scrambled bits have passed through its register, the receiver matches the transmitter by itself.

Both registers shift only when a bit arrives on a valid strobe. A wrapper connects the scrambler output to the descrambler input for loopback. It has a single-cycle link-error injection input, so that error spreading can be observed. Each side has its own synchronous active-high reset. Every output is registered, so the wrapper adds one cycle of latency per side.

Top module: `ssc_link_top`

## Requirements
- R1: While a side's reset is high at a clock edge, that side's register stages, its valid output and its data output are all cleared to 0.
- R2: For a message bit taken with `msg_valid` high, `link_bit` on the next cycle equals that bit XOR stage 3 XOR stage 4 of the scrambler register, and `link_valid` is high for exactly that one cycle.
- R3: The scrambled bit is shifted into stage 1 of the scrambler register (stage 1 moves to 2, 2 to 3, 3 to 4), so later outputs depend on earlier scrambled bits.
- R4: When a side's valid input is low, its register does not move and its valid output drops, whatever the data input carries.
- R5: The descrambler shifts each received link bit (`link_bit` XOR `link_flip`) into its own stage 1. It outputs that bit XOR its stage 3 XOR its stage 4 on `rx_bit` one cycle later, with `rx_valid` high for that cycle.
- R6: After both sides start from reset together, every `rx_bit` equals the message bit accepted two cycles earlier, whatever the gaps between strobes.
- R7: After the descrambler alone is reset while the scrambler keeps its state, the fifth and every later received bit are recovered correctly.
- R8: A single link bit inverted with `link_flip` corrupts exactly three recovered bits: the one carried by that link bit and the ones received third and fourth after it. All other recovered bits stay correct.
- R9: Resetting the descrambler has no effect on the scrambler, which keeps accepting bits and producing link output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_scr | input | 1 | Synchronous active-high reset of the scrambler |
| rst_dsc | input | 1 | Synchronous active-high reset of the descrambler |
| msg_valid | input | 1 | Message bit strobe |
| msg_bit | input | 1 | Message bit to scramble |
| link_flip | input | 1 | Inverts the link bit seen by the descrambler this cycle |
| link_valid | output | 1 | Scrambled bit valid (registered) |
| link_bit | output | 1 | Scrambled bit (registered) |
| rx_valid | output | 1 | Recovered bit valid (registered) |
| rx_bit | output | 1 | Recovered message bit (registered) |

## Verification
The embedded assertions check, on every cycle, the properties that hold locally. These are: the register is cleared after reset, it holds still without a strobe, the scrambled bit becomes stage 1, a received bit becomes stage 1 with a valid output one cycle later, and the scrambler carries on while only the descrambler is in reset. End-to-end recovery, the exact three-bit error footprint after an injected flip, and resynchronization from mismatched register contents all depend on long bit histories. Only the bench's reference model, running over whole streams, can show those.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int unsigned SSC_STAGES = 4;
  // stages 3 and 4 (bit 2 and bit 3, stage 1 is bit 0)
  localparam logic [SSC_STAGES-1:0] SSC_TAPS = 4'b1100;
endpackage

// File: rtl/ssc_shift_taps.sv
module ssc_shift_taps #(
  parameter int unsigned STAGES = ssc_pkg::SSC_STAGES,
  parameter logic [STAGES-1:0] TAPS = ssc_pkg::SSC_TAPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              din,
  output logic              tap_bit,
  output logic [STAGES-1:0] stages
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst)
      stg_q <= '0;
    else if (shift_en)
      stg_q <= {stg_q[STAGES-2:0], din};
  end

  assign tap_bit = ^(stg_q & TAPS);
  assign stages  = stg_q;

  assert_reset_clears_R1: assert property (@(posedge clk)
    $past(rst) |-> (stg_q == '0));

  assert_hold_without_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(stg_q));
endmodule

// File: rtl/ssc_scrambler.sv
module ssc_scrambler #(
  parameter int unsigned STAGES = ssc_pkg::SSC_STAGES,
  parameter logic [STAGES-1:0] TAPS = ssc_pkg::SSC_TAPS
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit
);
  logic              tap;
  logic              mixed;
  logic [STAGES-1:0] stg;

  assign mixed = in_bit ^ tap;

  ssc_shift_taps #(.STAGES(STAGES), .TAPS(TAPS)) u_reg (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(mixed),
    .tap_bit(tap), .stages(stg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_bit <= mixed;
    end
  end

  // scrambled output must be the bit that entered stage 1
  assert_feedback_into_stage1_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (stg[0] == out_bit));
endmodule

// File: rtl/ssc_descrambler.sv
module ssc_descrambler #(
  parameter int unsigned STAGES = ssc_pkg::SSC_STAGES,
  parameter logic [STAGES-1:0] TAPS = ssc_pkg::SSC_TAPS
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit
);
  logic              tap;
  logic [STAGES-1:0] stg;

  ssc_shift_taps #(.STAGES(STAGES), .TAPS(TAPS)) u_reg (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(in_bit),
    .tap_bit(tap), .stages(stg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_bit <= in_bit ^ tap;
    end
  end

  assert_received_bit_loaded_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid && (stg[0] == $past(in_bit))));
endmodule

// File: rtl/ssc_link_top.sv
module ssc_link_top #(
  parameter int unsigned STAGES = ssc_pkg::SSC_STAGES,
  parameter logic [STAGES-1:0] TAPS = ssc_pkg::SSC_TAPS
) (
  input  logic clk,
  input  logic rst_scr,
  input  logic rst_dsc,
  input  logic msg_valid,
  input  logic msg_bit,
  input  logic link_flip,
  output logic link_valid,
  output logic link_bit,
  output logic rx_valid,
  output logic rx_bit
);
  logic link_rx;

  ssc_scrambler #(.STAGES(STAGES), .TAPS(TAPS)) u_scr (
    .clk(clk), .rst(rst_scr), .in_valid(msg_valid), .in_bit(msg_bit),
    .out_valid(link_valid), .out_bit(link_bit)
  );

  assign link_rx = link_bit ^ link_flip;

  ssc_descrambler #(.STAGES(STAGES), .TAPS(TAPS)) u_dsc (
    .clk(clk), .rst(rst_dsc), .in_valid(link_valid), .in_bit(link_rx),
    .out_valid(rx_valid), .out_bit(rx_bit)
  );

  assert_scrambler_ignores_rx_reset_R9: assert property (@(posedge clk) disable iff (rst_scr)
    (rst_dsc && msg_valid) |=> link_valid);
endmodule

// File: tb/ssc_link_top_bench.sv
module ssc_link_top_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_scr = 1'b1, rst_dsc = 1'b1;
  logic msg_valid = 1'b0, msg_bit = 1'b0, link_flip = 1'b0;
  logic link_valid, link_bit, rx_valid, rx_bit;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ssc_link_top u_ssc_link_top (
    .clk(clk), .rst_scr(rst_scr), .rst_dsc(rst_dsc),
    .msg_valid(msg_valid), .msg_bit(msg_bit), .link_flip(link_flip),
    .link_valid(link_valid), .link_bit(link_bit),
    .rx_valid(rx_valid), .rx_bit(rx_bit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  tx_hist[$];   // scrambled bits sent, newest last
  int  rx_hist[$];   // bits received by descrambler, newest last
  int  msg_q[$];     // message bits in flight
  int  mode_q[$];    // 0 plain, 1 skip (resync), 2 corrupted
  int  e_lv = 0, e_lb = 0, e_rv = 0, e_rb = 0;
  int  rx_idx = 0;
  int  flip_at = -100;
  bit  resync = 1'b0;

  function automatic int older(input int h[$], input int k);
    return (h.size() >= k) ? h[h.size()-k] : 0;
  endfunction

  always @(posedge clk) begin
    int d, y, md;
    // receive side consumes last cycle's link output
    if (rst_dsc) begin
      if (e_lv != 0 && msg_q.size() > 0) void'(msg_q.pop_front());
      rx_hist.delete();
      e_rv = 0; e_rb = 0; rx_idx = 0; flip_at = -100;
    end else if (e_lv != 0) begin
      d = e_lb ^ int'(link_flip);
      if (link_flip) flip_at = rx_idx;
      e_rb = d ^ older(rx_hist, 3) ^ older(rx_hist, 4);
      rx_hist.push_back(d);
      if (rx_hist.size() > 8) void'(rx_hist.pop_front());
      e_rv = 1;
      if (resync && rx_idx < 4) md = 1;
      else if (rx_idx == flip_at || rx_idx == flip_at + 3 || rx_idx == flip_at + 4) md = 2;
      else md = 0;
      mode_q.push_back(md);
      rx_idx++;
    end else begin
      e_rv = 0;
    end
    // transmit side
    if (rst_scr) begin
      tx_hist.delete();
      e_lv = 0; e_lb = 0;
    end else if (msg_valid) begin
      y = int'(msg_bit) ^ older(tx_hist, 3) ^ older(tx_hist, 4);
      tx_hist.push_back(y);
      if (tx_hist.size() > 8) void'(tx_hist.pop_front());
      msg_q.push_back(int'(msg_bit));
      e_lv = 1; e_lb = y;
    end else begin
      e_lv = 0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    int m, md;
    chk((int'(link_valid) == e_lv) && (e_lv == 0 || int'(link_bit) == e_lb),
        "R2 R3 link", {link_valid, link_bit}, (e_lv << 1) | (e_lv != 0 ? e_lb : int'(link_bit)));
    chk((int'(rx_valid) == e_rv) && (e_rv == 0 || int'(rx_bit) == e_rb),
        "R5 rx", {rx_valid, rx_bit}, (e_rv << 1) | (e_rv != 0 ? e_rb : int'(rx_bit)));
    if (rx_valid && msg_q.size() > 0 && mode_q.size() > 0) begin
      m  = msg_q.pop_front();
      md = mode_q.pop_front();
      if (md == 0)
        chk(int'(rx_bit) == m, resync ? "R7 recover" : "R6 recover", rx_bit, m);
      else if (md == 2)
        chk(int'(rx_bit) == (m ^ 1), "R8 error span", rx_bit, m ^ 1);
    end
  end

  task automatic drive(input bit v, input bit b, input bit f);
    @(negedge clk);
    msg_valid = v; msg_bit = b; link_flip = f;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'($urandom), 1'b0);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    chk(!link_valid && !link_bit && !rx_valid && !rx_bit, "R1 reset outputs",
        {link_valid, link_bit, rx_valid, rx_bit}, 0);
    @(negedge clk); rst_scr = 1'b0; rst_dsc = 1'b0;

    phase = "R2 R6 back-to-back";
    for (int i = 0; i < 60; i++) drive(1'b1, 1'($urandom), 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, 1'b0);   // all-zero message
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b1, 1'b0);   // all-one message
    idle(4);

    phase = "R4 gaps";
    for (int i = 0; i < 120; i++) drive(1'($urandom), 1'($urandom), 1'b0);
    idle(4);

    phase = "R8 flip";
    for (int i = 0; i < 30; i++) drive(1'b1, 1'($urandom), i == 12);
    idle(4);
    phase = "R8 flip with gaps";
    for (int i = 0; i < 40; i++) drive((i % 3) != 1, 1'($urandom), 1'b0);
    for (int i = 0; i < 30; i++) drive(1'b1, 1'($urandom), i == 5);
    idle(4);

    phase = "R7 R9 rx-only reset";
    for (int i = 0; i < 20; i++) drive(1'b1, 1'($urandom), 1'b0);
    @(negedge clk); resync = 1'b1; rst_dsc = 1'b1;
    for (int i = 0; i < 3; i++) drive(1'b1, 1'($urandom), 1'b0);
    chk(!rx_valid && !rx_bit, "R1 rx side held in reset", {rx_valid, rx_bit}, 0);
    chk(link_valid == 1'b1, "R9 scrambler runs", link_valid, 1);
    @(negedge clk); rst_dsc = 1'b0;
    for (int i = 0; i < 40; i++) drive(1'b1, 1'($urandom), 1'b0);
    idle(4);

    phase = "R1 mid-run reset";
    for (int i = 0; i < 10; i++) drive(1'b1, 1'($urandom), 1'b0);
    @(negedge clk); msg_valid = 1'b0; rst_scr = 1'b1; rst_dsc = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!link_valid && !link_bit && !rx_valid && !rx_bit, "R1 mid-run reset outputs",
        {link_valid, link_bit, rx_valid, rx_bit}, 0);
    resync = 1'b0;
    @(negedge clk); rst_scr = 1'b0; rst_dsc = 1'b0;
    phase = "R6 after reset";
    for (int i = 0; i < 30; i++) drive(1'b1, 1'($urandom), 1'b0);
    idle(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog [%s] actual=%0d expected=%0d", phase, 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule